// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous single-port SRAM that has no turnaround gap. A read and a write can follow each other on consecutive clocks. Every command input is sampled on the rising clock edge. Read data flows through without a register: data for a read address sampled at one edge is driven during the following cycle. Write data is taken one enabled edge after its address. The two directions therefore never contend for the data bus.

One address produces a burst of four beats. The burst order is either linear or interleaved, chosen by an asynchronous mode input. A clock-enable input freezes the whole block. Three chip enables can deselect the device. Deselecting ends a burst but does not drop a write beat that still waits for its data.

A three-state control machine tracks the current beat: `ST_IDLE`, `ST_READ` and `ST_WRITE`. At each enabled edge one of five transitions applies:
- *load-read*: start strobe low, selected, write enable high.
- *load-write*: start strobe low, selected, write enable low.
- *deselect*: start strobe low and at least one chip enable inactive. The next state is `ST_IDLE`.
- *advance*: start strobe high. The beat counter steps and the state is kept; `ST_IDLE` stays idle.
- *stall*: clock enable high. Every register holds.

Top module: `sram_ft_zbt`

## Requirements
- R1: At an edge with cen_n=0, adv_ld_n=0, ce1_n=0, ce2=1, ce3_n=0 and we_n=1, a read burst starts at addr. During the next cycle dq_oe=1 and dq_out equals the stored word at that address.
- R2: At a load edge with we_n=0, a write beat is registered. The dq_in value present at the next enabled edge is stored at the beat address. bws_n[0]=0 enables bits 8:0 and bws_n[1]=0 enables bits 17:9; a lane whose select is 1 keeps its old contents.
- R3: A read of an address loaded on the clock right after the write to that address returns the new data. A write may directly follow a read. No idle cycle is needed in either direction.
- R4: With adv_ld_n=1 at an enabled edge, an active burst moves to its next beat and reuses the access type. After four beats the order wraps to the first beat.
- R5: With mode=0 (linear), beat k of a burst starting at address A uses the address with the upper bits of A and low two bits (A[1:0]+k) mod 4.
- R6: With mode=1 (interleaved), beat k uses the low two bits A[1:0] XOR k.
- R7: mode is asynchronous. Changing it in the middle of a burst changes the address of the current beat, and dq_out, without a clock edge.
- R8: While cen_n=1, every input is ignored and every register holds. A read beat keeps its output. A pending write stores the dq_in present at the next edge with cen_n=0.
- R9: A load edge with any chip enable inactive starts no operation and ends the burst. dq_oe is 0 in the following cycle, and later advance edges start nothing.
- R10: A write beat registered just before a deselect edge is still completed with the dq_in present at that deselect edge.
- R11: oe_n=1 forces dq_oe=0 at once, whatever the internal state.
- R12: After reset the block is idle and dq_oe=0.
- R13: dq_oe is 0 during every cycle whose current beat is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Write enable, active low, sampled at load |
| bws_n | input | 2 | Byte-lane write selects, active low, one per 9-bit half |
| addr | input | 10 | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mode | input | 1 | Asynchronous burst order: 0 linear, 1 interleaved |
| dq_in | input | 18 | Data-bus input side |
| dq_out | output | 18 | Data-bus output side |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The bench uses the default parameters: 10 address bits, 18 data bits and two 9-bit lanes. With a depth of 1K words, a preload pass can write every word. Every later random read then has a known expected value and is never compared against an unknown cell. Two lanes are enough to reach both halves of the byte gating. The 2-bit beat counter is small enough that short random bursts hit every wrap and both orders many times.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } beat_t;

    // Low two address bits of beat k, for either burst order.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] k,
                                               input logic       interleave);
        return interleave ? (start ^ k) : 2'(start + k);
    endfunction

endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
    import sram_ft_pkg::*;
#(
    parameter int AW = 10,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          sel_ok,
    input  logic          adv_ld_n,
    input  logic          we_n,
    input  logic [NB-1:0] bws_n,
    input  logic [AW-1:0] addr,
    output beat_t         state,
    output logic [AW-1:0] base,
    output logic [1:0]    cnt,
    output logic [NB-1:0] bws_q,
    output logic          rd_drive,
    output logic          wr_commit
);

    beat_t         state_nx;
    logic [AW-1:0] base_nx;
    logic [1:0]    cnt_nx;
    logic [NB-1:0] bws_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            base  <= '0;
            cnt   <= '0;
            bws_q <= '1;
        end else begin
            state <= state_nx;
            base  <= base_nx;
            cnt   <= cnt_nx;
            bws_q <= bws_nx;
        end
    end

    // Next-state: stall, load-read, load-write, deselect, advance
    always_comb begin
        state_nx = state;
        base_nx  = base;
        cnt_nx   = cnt;
        bws_nx   = bws_q;
        if (!cen_n) begin
            if (!adv_ld_n) begin
                if (sel_ok) begin
                    state_nx = we_n ? ST_READ : ST_WRITE;
                    base_nx  = addr;
                    cnt_nx   = 2'd0;
                    bws_nx   = bws_n;
                end else begin
                    state_nx = ST_IDLE;
                end
            end else begin
                unique case (state)
                    ST_READ, ST_WRITE: begin
                        cnt_nx = 2'(cnt + 2'd1);
                        bws_nx = bws_n;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs decoded from the current beat
    always_comb begin
        rd_drive  = 1'b0;
        wr_commit = 1'b0;
        unique case (state)
            ST_READ:  rd_drive  = 1'b1;
            ST_WRITE: wr_commit = 1'b1;
            default: ;
        endcase
    end

    assert_cen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(state) && $stable(cnt) && $stable(base)));

    assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld_n && sel_ok) |=> (cnt == 2'd0 && base == $past(addr)));

    assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld_n && state != ST_IDLE) |=> (cnt == 2'($past(cnt) + 2'd1)));

    assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld_n && !sel_ok) |=> (state == ST_IDLE));

endmodule

// File: rtl/sram_ft_addr.sv
module sram_ft_addr
    import sram_ft_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    cnt,
    input  logic          mode,
    output logic [AW-1:0] beat_addr
);

    localparam int HI = AW - 1;

    always_comb begin
        beat_addr = {base[HI:2], beat_offset(base[1:0], cnt, mode)};
    end

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
    parameter int AW = 10,
    parameter int DW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          commit,
    input  logic [NB-1:0] lane_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int BW    = DW / NB;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (commit && !lane_n[g]) begin
                mem[addr] <= wdata[g*BW +: BW];
            end
        end

        assign rdata[g*BW +: BW] = mem[addr];
    end

endmodule

// File: rtl/sram_ft_zbt.sv
module sram_ft_zbt
    import sram_ft_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adv_ld_n,
    input  logic          we_n,
    input  logic [NB-1:0] bws_n,
    input  logic [AW-1:0] addr,
    input  logic          oe_n,
    input  logic          mode,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    beat_t         state;
    logic [AW-1:0] base;
    logic [1:0]    cnt;
    logic [NB-1:0] bws_q;
    logic          rd_drive;
    logic          wr_commit;
    logic [AW-1:0] beat_addr;
    logic          sel_ok;

    assign sel_ok = !ce1_n && ce2 && !ce3_n;

    sram_ft_ctrl #(.AW(AW), .NB(NB)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel_ok(sel_ok),
        .adv_ld_n(adv_ld_n), .we_n(we_n), .bws_n(bws_n), .addr(addr),
        .state(state), .base(base), .cnt(cnt), .bws_q(bws_q),
        .rd_drive(rd_drive), .wr_commit(wr_commit)
    );

    sram_ft_addr #(.AW(AW)) addr_i (
        .base(base), .cnt(cnt), .mode(mode), .beat_addr(beat_addr)
    );

    sram_ft_array #(.AW(AW), .DW(DW), .NB(NB)) array_i (
        .clk(clk), .commit(wr_commit && !cen_n), .lane_n(bws_q),
        .addr(beat_addr), .wdata(dq_in), .rdata(dq_out)
    );

    assign dq_oe = rd_drive && !oe_n;

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_quiet_on_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> !dq_oe);

endmodule

// File: tb/sram_ft_zbt_tb_top.sv
module sram_ft_zbt_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 18;
    localparam int NB = 2;
    localparam int BW = DW / NB;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n, cen_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n, oe_n, mode;
    logic [NB-1:0] bws_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in, dq_out;
    logic dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_state;   // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic [NB-1:0] m_bws;

    sram_ft_zbt #(.AW(AW), .DW(DW), .NB(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bws_n(bws_n),
        .addr(addr), .oe_n(oe_n), .mode(mode), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic md);
        logic [1:0] o;
        o = md ? (b[1:0] ^ k) : 2'(b[1:0] + k);
        return {b[AW-1:2], o};
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [NB-1:0] bw);
        logic [DW-1:0] r;
        r = old;
        for (int g = 0; g < NB; g++)
            if (!bw[g]) r[g*BW +: BW] = nw[g*BW +: BW];
        return r;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_state = 0; m_base = '0; m_cnt = '0; m_bws = '1;
        end else if (!cen_n) begin
            if (m_state == 2) begin
                logic [AW-1:0] wa;
                wa = exp_addr(m_base, m_cnt, mode);
                ref_mem[wa] = merge(ref_mem[wa], dq_in, m_bws);
            end
            if (!adv_ld_n) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    m_state = we_n ? 1 : 2;
                    m_base = addr; m_cnt = 2'd0; m_bws = bws_n;
                end else begin
                    m_state = 0;
                end
            end else if (m_state != 0) begin
                m_cnt = 2'(m_cnt + 2'd1);
                m_bws = bws_n;
            end
        end
    endtask

    task automatic check_outputs(string tag);
        logic eoe;
        eoe = (m_state == 1) && !oe_n;
        check(tag, DW'(dq_oe), DW'(eoe));
        if (eoe) check(tag, dq_out, ref_mem[exp_addr(m_base, m_cnt, mode)]);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic drive(bit cen, bit adv, bit we, logic [NB-1:0] bw, logic [AW-1:0] a);
        cen_n = cen; adv_ld_n = adv; we_n = we; bws_n = bw; addr = a;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        dq_in = DW'($urandom);
    endtask

    task automatic load_rd(logic [AW-1:0] a, string tag);
        drive(0, 0, 1, '1, a); step(tag);
    endtask

    task automatic load_wr(logic [AW-1:0] a, logic [NB-1:0] bw, string tag);
        drive(0, 0, 0, bw, a); step(tag);
    endtask

    task automatic desel(logic [DW-1:0] d, string tag);
        drive(0, 0, 1, '1, '0); ce2 = 1'b0; dq_in = d; step(tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; oe_n = 0; mode = 0;
        drive(1, 1, 1, '1, '0);
        @(negedge clk);
        step("R12"); step("R12");
        check("R12", DW'(dq_oe), '0);
        rst_n = 1;
        step("R12");

        // preload every word with full-width write bursts
        for (int b = 0; b < DEPTH / 4; b++) begin
            load_wr(AW'(b * 4), '0, "R13");
            for (int k = 0; k < 3; k++) begin
                drive(0, 1, 1, '0, '0); step("R2");
            end
        end
        desel(DW'($urandom), "R10");

        // R1 single read
        load_rd(AW'(5), "R1");

        // R5 linear burst from offset 1, wraps (R4)
        mode = 0;
        load_rd(AW'(17), "R5");
        for (int k = 0; k < 3; k++) begin
            drive(0, 1, 1, '1, '0); step("R5");
        end
        drive(0, 1, 1, '1, '0); step("R4");

        // R6 interleaved burst from offset 2
        mode = 1;
        load_rd(AW'(34), "R6");
        for (int k = 0; k < 3; k++) begin
            drive(0, 1, 1, '1, '0); step("R6");
        end

        // R7 mode flip mid-burst, no clock
        mode = 0;
        #1 check("R7", dq_out, ref_mem[exp_addr(m_base, m_cnt, 1'b0)]);
        mode = 1;
        #1 check("R7", dq_out, ref_mem[exp_addr(m_base, m_cnt, 1'b1)]);
        mode = 0;

        // R2 byte lanes
        load_wr(AW'(40), 2'b10, "R2");
        desel(18'h3FFFF, "R2");
        load_rd(AW'(40), "R2");
        load_wr(AW'(44), 2'b01, "R2");
        desel(18'h00000, "R2");
        load_rd(AW'(44), "R2");

        // R3 read right after write, write right after read
        load_wr(AW'(60), '0, "R3");
        drive(0, 0, 1, '1, AW'(60)); dq_in = 18'h2A5A5; step("R3");
        check("R3", dq_out, 18'h2A5A5);
        load_wr(AW'(60), '0, "R3");
        check("R3", DW'(dq_oe), '0);
        drive(0, 0, 1, '1, AW'(60)); dq_in = 18'h15A5A; step("R3");

        // R8 stall holds a read, then a pending write waits
        load_rd(AW'(70), "R8");
        drive(1, 0, 0, '0, AW'(200)); step("R8");
        step("R8");
        load_wr(AW'(80), '0, "R8");
        drive(1, 0, 1, '1, AW'(300)); dq_in = 18'h11111; step("R8");
        desel(18'h22222, "R8");
        load_rd(AW'(80), "R8");
        check("R8", dq_out, 18'h22222);

        // R9 deselect ends a burst, each chip enable
        load_rd(AW'(90), "R9");
        desel('0, "R9");
        drive(0, 1, 1, '1, '0); step("R9");
        check("R9", DW'(dq_oe), '0);
        load_rd(AW'(91), "R9");
        drive(0, 0, 1, '1, '0); ce1_n = 1'b1; step("R9");
        load_rd(AW'(92), "R9");
        drive(0, 0, 1, '1, '0); ce3_n = 1'b1; step("R9");

        // R10 pending write completes at deselect
        load_wr(AW'(100), '0, "R10");
        desel(18'h0C3C3, "R10");
        load_rd(AW'(100), "R10");
        check("R10", dq_out, 18'h0C3C3);

        // R11 async output enable
        load_rd(AW'(110), "R11");
        oe_n = 1;
        #1 check("R11", DW'(dq_oe), '0);
        oe_n = 0;
        #1 check("R11", DW'(dq_oe), DW'(1));

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 3) begin
                drive(0, 0, $urandom % 2, NB'($urandom), AW'($urandom));
                if ($urandom % 8 == 0) begin
                    int s; s = int'($urandom % 3);
                    if (s == 0) ce1_n = 1; else if (s == 1) ce2 = 0; else ce3_n = 1;
                end
            end else if (r < 6) begin
                drive(0, 1, 1, NB'($urandom), AW'($urandom));
            end else if (r == 6) begin
                drive(1, $urandom % 2, $urandom % 2, NB'($urandom), AW'($urandom));
            end else begin
                drive(0, 0, 1, '1, '0); ce2 = 0;
            end
            if ($urandom % 16 == 0) mode = ~mode;
            oe_n = ($urandom % 8 == 0);
            step("R4");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule